// File: doc/BRIEF.md
# External Clock Pin Edge Synchronizer

This block takes a free-running external clock pin that has no timing relation to the system clock and turns its transitions into count-enable pulses for a timer/counter. The pin is sampled once per system clock cycle. A half-cycle capture stage samples the pin on the falling system clock edge, which stands in for a latch that is transparent while the clock is high. A rising-edge register follows it. Only this synchronized copy feeds the edge logic.

A 3-bit clock-select code chooses what gets counted. Code 3'b111 counts rising pin edges and code 3'b110 counts falling pin edges. Every other code forces the pulse low, but the synchronizer keeps following the pin. There is no prescaler on this path, so each selected edge gives exactly one pulse one cycle wide. An edge that arrives in the high phase of the clock leaves the block two rising clock edges later. An edge that arrives in the low phase takes three. Because the counter adds one more register stage, the pin-to-count delay is 2.5 to 3.5 cycles. The pin must stay in each level for more than one system clock period, and the select code should only change while the pin has been steady for a cycle.

Top module: `extclk_edge_sync`

## Requirements
- R1: While the reset is active, and during the first cycle after the reset is released, the count pulse is low. All synchronizer and history state clears to 0.
- R2: With select code 3'b111, each 0-to-1 transition of the pin produces exactly one count pulse, and a 1-to-0 transition produces none.
- R3: With select code 3'b110, each 1-to-0 transition of the pin produces exactly one count pulse, and a 0-to-1 transition produces none.
- R4: With any select code other than 3'b111 or 3'b110, the count pulse stays low. The synchronized pin history still updates, so an edge seen just after switching back to a counting code is judged against the pin's true previous level.
- R5: A pin change made while the system clock is high shows up on the count pulse after the second following rising clock edge, not after the first.
- R6: A pin change made while the system clock is low shows up on the count pulse after the third following rising clock edge, not after the second.
- R7: The count pulse is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous external clock pin |
| clk_sel | input | 3 | Clock-select code: 7 counts rising edges, 6 counts falling edges, other codes block the pulse |
| cnt_pulse | output | 1 | One-cycle count-enable pulse |

## Verification
A stimulus table drives the pin through isolated single-level steps and through stretches held for several cycles. The same pin shape is run under the rising code, the falling code and blocking codes, which separates correct polarity selection from a detector that fires on any change. Some select changes come right after pin edges, which shows whether the history register kept tracking while blocked. Directed tests then place a pin edge in the high phase and then in the low phase of the clock to tell the half-cycle capture apart from a plain two-register synchronizer. A reset applied with the pin high shows that state clears to 0 rather than to the pin level.

// File: rtl/extclk_pkg.sv
package extclk_pkg;

   localparam int unsigned SEL_W = 3;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } edge_mode_e;

   localparam logic [SEL_W-1:0] SEL_RISE_DEFAULT = 3'b111;
   localparam logic [SEL_W-1:0] SEL_FALL_DEFAULT = 3'b110;

endpackage

// File: rtl/extclk_capture.sv
module extclk_capture #(
   parameter int unsigned SYNC_STAGES = 1,
   parameter bit          HALF_CYCLE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   output logic pin_sync
);

   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("extclk_capture: SYNC_STAGES must be at least 1");
   end

   logic front;

   if (HALF_CYCLE) begin : g_half
      // falling-edge capture models the latch that is open while clk is high
      logic neg_q;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) neg_q <= 1'b0;
         else        neg_q <= pin_raw;
      end
      assign front = neg_q;
   end else begin : g_full
      logic pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pre_q <= 1'b0;
         else        pre_q <= pin_raw;
      end
      assign front = pre_q;
   end

   logic [SYNC_STAGES-1:0] chain_q;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_chain
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= front;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   end

   assign pin_sync = chain_q[LAST];

endmodule

// File: rtl/extclk_edge.sv
module extclk_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_sync,
   output logic pin_hist,
   output logic rise_det,
   output logic fall_det
);

   logic hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= pin_sync;
   end

   assign pin_hist = hist_q;
   assign rise_det = pin_sync & ~hist_q;
   assign fall_det = ~pin_sync & hist_q;

endmodule

// File: rtl/extclk_select.sv
module extclk_select
   import extclk_pkg::*;
#(
   parameter logic [SEL_W-1:0] SEL_RISE = SEL_RISE_DEFAULT,
   parameter logic [SEL_W-1:0] SEL_FALL = SEL_FALL_DEFAULT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic             rise_det,
   input  logic             fall_det,
   output logic             pulse
);

   if (SEL_RISE == SEL_FALL) begin : g_bad_codes
      $error("extclk_select: rising and falling codes must differ");
   end

   edge_mode_e mode;
   logic       hit;
   logic       pulse_q;

   always_comb begin
      if (clk_sel == SEL_RISE)      mode = EDGE_RISE;
      else if (clk_sel == SEL_FALL) mode = EDGE_FALL;
      else                          mode = EDGE_NONE;
   end

   always_comb begin
      unique case (mode)
         EDGE_RISE: hit = rise_det;
         EDGE_FALL: hit = fall_det;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= hit;
   end

   assign pulse = pulse_q;

endmodule

// File: rtl/extclk_edge_sync.sv
module extclk_edge_sync
   import extclk_pkg::*;
#(
   parameter int unsigned      SYNC_STAGES = 1,
   parameter bit               HALF_CYCLE  = 1'b1,
   parameter logic [SEL_W-1:0] SEL_RISE    = SEL_RISE_DEFAULT,
   parameter logic [SEL_W-1:0] SEL_FALL    = SEL_FALL_DEFAULT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_raw,
   input  logic [SEL_W-1:0] clk_sel,
   output logic             cnt_pulse
);

   logic pin_sync;
   logic pin_hist;
   logic rise_det;
   logic fall_det;

   extclk_capture #(
      .SYNC_STAGES (SYNC_STAGES),
      .HALF_CYCLE  (HALF_CYCLE)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_raw  (pin_raw),
      .pin_sync (pin_sync)
   );

   extclk_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pin_sync),
      .pin_hist (pin_hist),
      .rise_det (rise_det),
      .fall_det (fall_det)
   );

   extclk_select #(
      .SEL_RISE (SEL_RISE),
      .SEL_FALL (SEL_FALL)
   ) u_select (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_sel  (clk_sel),
      .rise_det (rise_det),
      .fall_det (fall_det),
      .pulse    (cnt_pulse)
   );

endmodule

// File: rtl/extclk_edge_sync_chk.sv
module extclk_edge_sync_chk
   import extclk_pkg::*;
#(
   parameter logic [SEL_W-1:0] SEL_RISE = SEL_RISE_DEFAULT,
   parameter logic [SEL_W-1:0] SEL_FALL = SEL_FALL_DEFAULT
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] clk_sel,
   input logic             pin_sync,
   input logic             cnt_pulse
);

   AST_QUIET_IN_RESET: assert property (@(posedge clk)
      !rst_n |-> !cnt_pulse);                                           // R1

   AST_RISE_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pin_sync) && clk_sel == SEL_RISE) |=> cnt_pulse);          // R2

   AST_FALL_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pin_sync) && clk_sel == SEL_FALL) |=> cnt_pulse);          // R3

   AST_BLOCKED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel != SEL_RISE && clk_sel != SEL_FALL) |=> !cnt_pulse);     // R4

   AST_NO_STEADY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(pin_sync) |=> !cnt_pulse);                                // R2

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_pulse |=> !cnt_pulse);                                        // R7

endmodule

bind extclk_edge_sync extclk_edge_sync_chk #(
   .SEL_RISE (SEL_RISE),
   .SEL_FALL (SEL_FALL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_sel   (clk_sel),
   .pin_sync  (pin_sync),
   .cnt_pulse (cnt_pulse)
);

// File: tb/extclk_edge_sync_test.sv
module extclk_edge_sync_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_raw = 1'b0;
   logic [2:0] clk_sel = 3'd0;
   logic       cnt_pulse;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   extclk_edge_sync uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_raw   (pin_raw),
      .clk_sel   (clk_sel),
      .cnt_pulse (cnt_pulse)
   );

   // {pin, sel[2:0], expected pulse after the rising edge that applies the row}
   localparam int NVEC = 21;
   localparam logic [4:0] VEC [NVEC] = '{
      {1'b1, 3'd7, 1'b0}, {1'b1, 3'd7, 1'b0}, {1'b1, 3'd7, 1'b1},
      {1'b0, 3'd7, 1'b0}, {1'b0, 3'd7, 1'b0}, {1'b1, 3'd7, 1'b0},
      {1'b0, 3'd7, 1'b0}, {1'b1, 3'd7, 1'b1}, {1'b1, 3'd6, 1'b0},
      {1'b1, 3'd6, 1'b0}, {1'b0, 3'd6, 1'b0}, {1'b0, 3'd6, 1'b0},
      {1'b1, 3'd0, 1'b1}, {1'b0, 3'd0, 1'b0}, {1'b1, 3'd0, 1'b0},
      {1'b1, 3'd7, 1'b0}, {1'b1, 3'd7, 1'b1}, {1'b1, 3'd3, 1'b0},
      {1'b0, 3'd3, 1'b0}, {1'b0, 3'd3, 1'b0}, {1'b0, 3'd3, 1'b0}
   };

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: cnt_pulse=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual=running expected=done");
      finish_run();
   end

   initial begin
      // R1: quiet during reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset", cnt_pulse, 1'b0);
      #1 rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // stimulus table: R2 rows 0-7, R3 rows 8-12, R4 rows 13-20
      for (int i = 0; i < NVEC; i++) begin
         @(posedge clk);
         #1;
         pin_raw = VEC[i][4];
         clk_sel = VEC[i][3:1];
         @(negedge clk);
         chk((i < 8) ? "R2 table" : (i < 13) ? "R3 table" : "R4 table",
             cnt_pulse, VEC[i][0]);
      end

      // R5: edge during high phase -> pulse after second rising edge
      @(posedge clk); #1 pin_raw = 1'b0; clk_sel = 3'd7;
      repeat (4) @(posedge clk);
      #1 pin_raw = 1'b1;
      @(posedge clk);
      @(negedge clk); chk("R5 early", cnt_pulse, 1'b0);
      @(posedge clk);
      @(negedge clk); chk("R5 on time", cnt_pulse, 1'b1);
      @(posedge clk);
      @(negedge clk); chk("R7 one cycle", cnt_pulse, 1'b0);

      // R6: edge during low phase -> pulse after third rising edge
      @(posedge clk); #1 pin_raw = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      #1 pin_raw = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk); chk("R6 early", cnt_pulse, 1'b0);
      @(posedge clk);
      @(negedge clk); chk("R6 on time", cnt_pulse, 1'b1);
      @(posedge clk);
      @(negedge clk); chk("R7 one cycle", cnt_pulse, 1'b0);

      // R1: reset with pin high clears state to 0, first cycle after release quiet
      @(posedge clk); #1 pin_raw = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b0; pin_raw = 1'b1;
      @(negedge clk); chk("R1 in reset", cnt_pulse, 1'b0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk); chk("R1 first cycle", cnt_pulse, 1'b0);
      @(posedge clk);
      @(negedge clk); chk("R1 second cycle", cnt_pulse, 1'b0);
      @(posedge clk);
      @(negedge clk); chk("R2 rise from cleared state", cnt_pulse, 1'b1);

      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule